// File: doc/BRIEF.md
# Acquire/Release Fence Micro-op Sequencer

This block sits between instruction decode and the memory pipeline. It takes one load-reserved, store-conditional or atomic read-modify-write instruction at a time, together with its acquire and release ordering bits, and emits the short micro-op sequence that carries out that instruction under release consistency. A release bit adds a fence ahead of the memory micro-op, and an acquire bit adds a fence behind it. So one instruction becomes one, two or three micro-ops.

Each micro-op leaves with a two-bit kind code, a tag copied from the instruction, and four flags: first and last mark the edges of the sequence, barrier marks a fence, and delayed-commit tells the pipeline that more micro-ops of the same instruction follow and must retire with it. Both edges use a valid/ready handshake. The block holds one instruction and does not accept the next until the last micro-op of the current one has been handed off.

Top module: `amo_fence_seq`

## Requirements
- R1: While reset is asserted and right after it, uop_valid_o is 0 and in_ready_o is 1.
- R2: With aq and rl both 0, a single micro-op is emitted with first=1, last=1, barrier=0, dcommit=0.
- R3: With only rl set, two micro-ops are emitted: a fence with first=1, last=0, barrier=1, dcommit=1, then the memory micro-op with first=0, last=1, barrier=0, dcommit=0.
- R4: With only aq set, two micro-ops are emitted: the memory micro-op with first=1, last=0, barrier=0, dcommit=1, then a fence with first=0, last=1, barrier=1, dcommit=0. No micro-op with last=1 has dcommit=1.
- R5: With aq and rl both set, three micro-ops are emitted: a fence (first=1, last=0, barrier=1, dcommit=1), the memory micro-op (first=0, last=0, barrier=0, dcommit=1), and a fence (first=0, last=1, barrier=1, dcommit=0).
- R6: Kind codes are 0 fence, 1 load-reserved, 2 store-conditional, 3 atomic RMW. The memory micro-op carries the instruction's kind; fences carry 0. barrier is 1 exactly when the kind is 0.
- R7: Every micro-op of a sequence carries the tag of the instruction that produced it.
- R8: While uop_valid_o=1 and uop_ready_i=0, the offered micro-op and all its fields stay unchanged in the next cycle.
- R9: in_ready_o is 0 from the cycle after an instruction is accepted until the cycle after its last micro-op is handed off; in_valid_i during that window is ignored and starts no sequence.
- R10: The first micro-op of an instruction is offered in the cycle after the instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Sequencer can accept an instruction |
| in_kind_i | input | 2 | Instruction kind: 1 LR, 2 SC, 3 AMO |
| in_aq_i | input | 1 | Acquire ordering bit |
| in_rl_i | input | 1 | Release ordering bit |
| in_tag_i | input | TAG_W | Instruction tag |
| uop_valid_o | output | 1 | Micro-op offered |
| uop_ready_i | input | 1 | Pipeline takes the micro-op |
| uop_kind_o | output | 2 | Micro-op kind: 0 fence, 1 LR, 2 SC, 3 AMO |
| uop_first_o | output | 1 | First micro-op of the instruction |
| uop_last_o | output | 1 | Last micro-op of the instruction |
| uop_barrier_o | output | 1 | Micro-op is a memory barrier |
| uop_dcommit_o | output | 1 | Commit deferred until later micro-ops retire |
| uop_tag_o | output | TAG_W | Tag of the parent instruction |

## Verification
The two events that meet in one cycle are the handoff of a sequence's last micro-op and a new instruction waiting on the input. The bench keeps in_valid_i high with a fresh instruction all through a running sequence, with uop_ready_i dropped at random, so the last handoff and the waiting instruction coincide again and again. It judges the outcome by requiring in_ready_o low in that cycle, the waiting instruction accepted only one cycle later, and its first micro-op, flags and tag matching a reference queue built from the requirements, with no micro-op lost or duplicated.

// File: rtl/amo_seq_pkg.sv
package amo_seq_pkg;

  typedef enum logic [1:0] {
    UOP_FENCE = 2'd0,
    UOP_LR    = 2'd1,
    UOP_SC    = 2'd2,
    UOP_AMO   = 2'd3
  } uop_kind_e;

  typedef enum logic [1:0] {
    STEP_REL = 2'd0,
    STEP_MEM = 2'd1,
    STEP_ACQ = 2'd2
  } step_e;

  typedef struct packed {
    logic first;
    logic last;
    logic barrier;
    logic dcommit;
  } uop_flags_t;

endpackage

// File: rtl/amo_seq_plan.sv
// Per-step micro-op contents and successor step.
module amo_seq_plan
  import amo_seq_pkg::*;
(
  input  step_e      step_i,
  input  logic       aq_i,
  input  logic       rl_i,
  input  uop_kind_e  mem_kind_i,
  output uop_kind_e  kind_o,
  output uop_flags_t flags_o,
  output logic       final_o,
  output step_e      next_step_o
);

  always_comb begin
    kind_o      = UOP_FENCE;
    flags_o     = '0;
    final_o     = 1'b1;
    next_step_o = STEP_MEM;
    case (step_i)
      STEP_REL: begin
        flags_o.first   = 1'b1;
        flags_o.barrier = 1'b1;
        flags_o.dcommit = 1'b1;
        final_o         = 1'b0;
        next_step_o     = STEP_MEM;
      end
      STEP_MEM: begin
        kind_o          = mem_kind_i;
        flags_o.first   = ~rl_i;
        flags_o.last    = ~aq_i;
        flags_o.dcommit = aq_i;
        final_o         = ~aq_i;
        next_step_o     = STEP_ACQ;
      end
      STEP_ACQ: begin
        flags_o.last    = 1'b1;
        flags_o.barrier = 1'b1;
        final_o         = 1'b1;
        next_step_o     = STEP_MEM;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/amo_seq_ctrl.sv
// Holds one instruction and walks its steps.
module amo_seq_ctrl
  import amo_seq_pkg::*;
#(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  uop_kind_e        in_kind_i,
  input  logic             in_aq_i,
  input  logic             in_rl_i,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic             out_ready_i,
  input  logic             final_i,
  input  step_e            next_step_i,
  output logic             in_ready_o,
  output logic             busy_o,
  output step_e            step_o,
  output logic             aq_o,
  output logic             rl_o,
  output uop_kind_e        kind_o,
  output logic [TAG_W-1:0] tag_o
);

  logic             busy_q;
  step_e            step_q;
  logic             aq_q, rl_q;
  uop_kind_e        kind_q;
  logic [TAG_W-1:0] tag_q;

  logic accept, fire;
  assign accept = in_valid_i & ~busy_q;
  assign fire   = busy_q & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= STEP_MEM;
      aq_q   <= 1'b0;
      rl_q   <= 1'b0;
      kind_q <= UOP_FENCE;
      tag_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      step_q <= in_rl_i ? STEP_REL : STEP_MEM;
      aq_q   <= in_aq_i;
      rl_q   <= in_rl_i;
      kind_q <= in_kind_i;
      tag_q  <= in_tag_i;
    end else if (fire) begin
      if (final_i) busy_q <= 1'b0;
      else         step_q <= next_step_i;
    end
  end

  assign in_ready_o = ~busy_q;
  assign busy_o     = busy_q;
  assign step_o     = step_q;
  assign aq_o       = aq_q;
  assign rl_o       = rl_q;
  assign kind_o     = kind_q;
  assign tag_o      = tag_q;

  AST_STEP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (step_q != 2'd3)); // R5

  AST_REL_NEEDS_RL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && step_q == STEP_REL |-> rl_q); // R3

  AST_ACQ_NEEDS_AQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && step_q == STEP_ACQ |-> aq_q); // R4

endmodule

// File: rtl/amo_fence_seq.sv
module amo_fence_seq
  import amo_seq_pkg::*;
#(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       in_kind_i,
  input  logic             in_aq_i,
  input  logic             in_rl_i,
  input  logic [TAG_W-1:0] in_tag_i,
  output logic             uop_valid_o,
  input  logic             uop_ready_i,
  output logic [1:0]       uop_kind_o,
  output logic             uop_first_o,
  output logic             uop_last_o,
  output logic             uop_barrier_o,
  output logic             uop_dcommit_o,
  output logic [TAG_W-1:0] uop_tag_o
);

  logic             busy, final_step, held_aq, held_rl;
  step_e            step, next_step;
  uop_kind_e        held_kind, cur_kind;
  uop_flags_t       cur_flags;
  logic [TAG_W-1:0] held_tag;

  amo_seq_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_kind_i   (uop_kind_e'(in_kind_i)),
    .in_aq_i     (in_aq_i),
    .in_rl_i     (in_rl_i),
    .in_tag_i    (in_tag_i),
    .out_ready_i (uop_ready_i),
    .final_i     (final_step),
    .next_step_i (next_step),
    .in_ready_o  (in_ready_o),
    .busy_o      (busy),
    .step_o      (step),
    .aq_o        (held_aq),
    .rl_o        (held_rl),
    .kind_o      (held_kind),
    .tag_o       (held_tag)
  );

  amo_seq_plan u_plan (
    .step_i      (step),
    .aq_i        (held_aq),
    .rl_i        (held_rl),
    .mem_kind_i  (held_kind),
    .kind_o      (cur_kind),
    .flags_o     (cur_flags),
    .final_o     (final_step),
    .next_step_o (next_step)
  );

  assign uop_valid_o   = busy;
  assign uop_kind_o    = cur_kind;
  assign uop_first_o   = cur_flags.first;
  assign uop_last_o    = cur_flags.last;
  assign uop_barrier_o = cur_flags.barrier;
  assign uop_dcommit_o = cur_flags.dcommit;
  assign uop_tag_o     = held_tag;

  AST_FIRST_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> uop_valid_o && uop_first_o); // R10

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o &&
      $stable({uop_kind_o, uop_first_o, uop_last_o, uop_barrier_o, uop_dcommit_o, uop_tag_o})); // R8

  AST_CONTINUE_NOT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && !uop_last_o |=> uop_valid_o && !uop_first_o); // R5

  AST_LAST_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && uop_last_o |=> in_ready_o && !uop_valid_o); // R9

  AST_LAST_NO_DCOMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_last_o |-> !uop_dcommit_o); // R4

  AST_FENCE_BARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> ((uop_kind_o == UOP_FENCE) == uop_barrier_o)); // R6

  AST_TAG_STABLE_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_last_o |=> $stable(uop_tag_o)); // R7

endmodule

// File: tb/amo_fence_seq_bench.sv
`timescale 1ns/1ps
module amo_fence_seq_bench;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_ni, in_valid, in_ready, in_aq, in_rl, uop_valid, uop_ready;
  logic [1:0]       in_kind, uop_kind;
  logic [TAG_W-1:0] in_tag, uop_tag;
  logic             uop_first, uop_last, uop_barrier, uop_dcommit;

  amo_fence_seq #(.TAG_W(TAG_W)) u_amo_fence_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_kind_i(in_kind), .in_aq_i(in_aq), .in_rl_i(in_rl), .in_tag_i(in_tag),
    .uop_valid_o(uop_valid), .uop_ready_i(uop_ready),
    .uop_kind_o(uop_kind), .uop_first_o(uop_first), .uop_last_o(uop_last),
    .uop_barrier_o(uop_barrier), .uop_dcommit_o(uop_dcommit), .uop_tag_o(uop_tag)
  );

  typedef struct packed {
    logic [1:0]       kind;
    logic             first, last, barrier, dc;
    logic [TAG_W-1:0] tag;
    logic [1:0]       shape; // 0 none, 1 rl, 2 aq, 3 both
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  bit   done = 0;
  bit   prev_stall = 0, prev_accept = 0;

  function automatic string shape_tag(logic [1:0] s);
    case (s)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Expected sequence built from R2..R5
  task automatic push_seq(input logic [1:0] k, input logic aq, input logic rl,
                          input logic [TAG_W-1:0] t);
    logic [1:0] sh;
    sh = {aq, rl};
    if (rl) exp_q.push_back('{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, t, sh});
    exp_q.push_back('{k, ~rl, ~aq, 1'b0, aq, t, sh});
    if (aq) exp_q.push_back('{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, t, sh});
  endtask

  // Called at a negedge: check outputs, then drive inputs for the next edge.
  task automatic step(input bit v, input logic [1:0] k, input logic aq,
                      input logic rl, input logic [TAG_W-1:0] t, input bit rdy);
    bit   busy_exp;
    exp_t e;
    busy_exp = (exp_q.size() != 0);
    check(in_ready == !busy_exp, "R9", "in_ready", in_ready, !busy_exp);
    check(uop_valid == busy_exp, prev_accept ? "R10" : "R9", "uop_valid", uop_valid, busy_exp);
    if (busy_exp && uop_valid) begin
      e = exp_q[0];
      check({uop_first, uop_last, uop_barrier, uop_dcommit} == {e.first, e.last, e.barrier, e.dc},
            prev_stall ? "R8" : shape_tag(e.shape), "flags",
            {uop_first, uop_last, uop_barrier, uop_dcommit}, {e.first, e.last, e.barrier, e.dc});
      check(uop_kind == e.kind, "R6", "kind", uop_kind, e.kind);
      check(uop_tag == e.tag, "R7", "tag", uop_tag, e.tag);
    end
    prev_accept = v && in_ready;
    prev_stall  = uop_valid && !rdy;
    if (uop_valid && rdy && busy_exp) void'(exp_q.pop_front());
    if (v && in_ready) push_seq(k, aq, rl, t);
    in_valid = v; in_kind = k; in_aq = aq; in_rl = rl; in_tag = t; uop_ready = rdy;
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_ni = 1'b0; in_valid = 0; in_kind = 2'd1; in_aq = 0; in_rl = 0; in_tag = '0; uop_ready = 0;
    repeat (3) @(negedge clk);
    check(uop_valid == 1'b0, "R1", "uop_valid in reset", uop_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(uop_valid == 1'b0 && in_ready == 1'b1, "R1", "after reset", {uop_valid, in_ready}, 2'b01);

    // Directed: each shape with every kind, ready held high
    for (int s = 0; s < 4; s++) begin
      for (int k = 1; k < 4; k++) begin
        step(1, 2'(k), s[1], s[0], 8'(16 * s + k), 1);
        repeat (4) step(0, 2'd0, 0, 0, 8'h00, 1);
      end
    end
    // Directed: both bits, next instruction waiting, ready stalled then released
    step(1, 2'd3, 1, 1, 8'hA5, 0);
    repeat (3) step(1, 2'd2, 0, 0, 8'h5A, 0); // R9 waiting input ignored
    repeat (2) step(1, 2'd2, 0, 0, 8'h5A, 1);
    step(1, 2'd2, 0, 0, 8'h5A, 0);
    repeat (6) step(1, 2'd1, 1, 0, 8'h3C, 1);
    repeat (6) step(0, 2'd0, 0, 0, 8'h00, 1);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) < 7, 2'(1 + $urandom % 3), 1'($urandom), 1'($urandom),
           8'($urandom), ($urandom % 10) < 6);
    end
    repeat (8) step(0, 2'd0, 0, 0, 8'h00, 1);
    check(exp_q.size() == 0, "R9", "drained", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule